// File: doc/BRIEF.md
# Quad-Lane Time-Multiplexed SIMD Execution Datapath

This block carries out one 16-element vector instruction on only four physical 32-bit lanes. It does this by stepping through the vector a quad at a time over four consecutive cycles. Two units share the same issue slot and run in parallel:

- an integer add-side unit with eight operations;
- a multiply-side unit that returns the low 32 bits of an unsigned product.

Each unit has its own pair of 16-element source vectors. Each unit also produces its own 16-element result and its own 16-bit write-enable mask.

An instruction may update two per-element flags, zero and negative, which are taken from the add-side result. Any instruction can limit its write enables to elements whose stored flags meet a chosen condition. A register move is expressed as an OR of a value with itself.

The issuing logic presents an instruction together with `issue` while `busy` is low. `done` pulses once all four quads are written. The results, masks and flags then hold until the next accepted instruction.

Top module: `quad_simd_dp`

## Requirements
- R1: During and directly after reset, `busy` and `done` are low and all results, both write-enable masks and both flag vectors are zero.
- R2: The add-side unit applies the operation selected by `add_op` to each element pair of `add_a` and `add_b`. The encodings are:

  | `add_op` | Operation | Notes |
  |---|---|---|
  | 0 | add | |
  | 1 | subtract | a minus b |
  | 2 | AND | |
  | 3 | OR | |
  | 4 | XOR | |
  | 5 | shift left | amount is b[4:0] |
  | 6 | logical shift right | amount is b[4:0] |
  | 7 | arithmetic shift right | amount is b[4:0] |

- R3: Each element of `mul_res` is the low 32 bits of the unsigned product of the matching elements of `mul_a` and `mul_b`.
- R4: Both units execute in the same instruction. Element i of each result, mask and flag vector depends only on element i of that unit's operands and element i of the stored flags. Element i occupies bits [32*i+31 : 32*i] of each vector port.
- R5: Acceptance and timing:
  - An instruction is accepted on a rising edge where `issue` is high and `busy` is low.
  - `busy` is then high for exactly 3 cycles.
  - `done` is high for one cycle, the cycle in which `busy` falls.
  - An instruction can be accepted in that same cycle, which gives one instruction every 4 cycles.
- R6: `issue` and all instruction inputs are ignored while `busy` is high. The running instruction's results are unchanged and no extra instruction starts.
- R7: When `set_flags` is high, `flag_z[i]` is set to whether add-side element i equals zero, and `flag_n[i]` to its bit 31. When `set_flags` is low, both flag vectors keep their values. While idle, flags and results hold.
- R8: The condition codes `add_cond` and `mul_cond` each set the per-element write enables for their unit:

  | Code | Name | Write enable is 1 when |
  |---|---|---|
  | 0 | never | never (all 0) |
  | 1 | always | always (all 1) |
  | 2 | if zero | Z = 1 |
  | 3 | if not zero | Z = 0 |
  | 4 | if negative | N = 1 |
  | 5 | if not negative | N = 0 |
  | 6, 7 | never | never (all 0) |

  The conditions use the flags as they stood before this instruction's own flag update.
- R9: A move is done as `add_op` = 3 (OR) with `add_a` equal to `add_b`, and returns the source value unchanged.
- R10: Quads are produced in ascending order. On the accepting edge, elements 0-3 of every output vector take their new values while elements 4-15 keep the previous instruction's values. Elements 4-7, 8-11 and 12-15 follow on the next three edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue | input | 1 | Instruction present |
| add_op | input | 3 | Add-side operation code |
| add_cond | input | 3 | Add-side write condition |
| mul_cond | input | 3 | Multiply-side write condition |
| set_flags | input | 1 | Update Z/N flags from add-side result |
| add_a | input | 512 | Add-side first operand, 16 x 32 |
| add_b | input | 512 | Add-side second operand / shift amount |
| mul_a | input | 512 | Multiply-side first operand |
| mul_b | input | 512 | Multiply-side second operand |
| busy | output | 1 | Quads 1-3 still in progress |
| done | output | 1 | Last quad written this cycle |
| add_res | output | 512 | Add-side result vector |
| mul_res | output | 512 | Multiply-side result vector |
| add_wen | output | 16 | Add-side per-element write enables |
| mul_wen | output | 16 | Multiply-side per-element write enables |
| flag_z | output | 16 | Per-element zero flags |
| flag_n | output | 16 | Per-element negative flags |

## Verification
The bench builds the block with its defaults: 16 elements, 4 lanes and 32-bit words. This gives four quad phases, so the switch from live ports in phase 0 to captured operands in phases 1-3 is exercised on every instruction. The bench also exercises the partial-update window in which only the first quad has changed.

Instructions are issued back to back. This brings within reach the edge where `done` and a new acceptance coincide, and the case where flags written by one instruction steer the masks of the next. Shift amounts cover the full 5-bit range, so sign fill on arithmetic shifts and products that overflow 32 bits both appear.

// File: rtl/simd_pkg.sv
package simd_pkg;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_SUB = 3'd1,
    OP_AND = 3'd2,
    OP_OR  = 3'd3,
    OP_XOR = 3'd4,
    OP_SHL = 3'd5,
    OP_SHR = 3'd6,
    OP_ASR = 3'd7
  } alu_op_e;

  typedef enum logic [2:0] {
    WC_NEVER  = 3'd0,
    WC_ALWAYS = 3'd1,
    WC_IFZ    = 3'd2,
    WC_IFNZ   = 3'd3,
    WC_IFN    = 3'd4,
    WC_IFNN   = 3'd5
  } wcond_e;

endpackage

// File: rtl/simd_add_lane.sv
module simd_add_lane
  import simd_pkg::*;
#(
  parameter int W = 32
) (
  input  alu_op_e        op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [W-1:0]   y
);
  localparam int SH_W = $clog2(W);

  logic [SH_W-1:0] sh;
  assign sh = b[SH_W-1:0];

  always_comb begin
    case (op)
      OP_ADD:  y = a + b;
      OP_SUB:  y = a - b;
      OP_AND:  y = a & b;
      OP_OR:   y = a | b;
      OP_XOR:  y = a ^ b;
      OP_SHL:  y = a << sh;
      OP_SHR:  y = a >> sh;
      OP_ASR:  y = W'($signed(a) >>> sh);
      default: y = a + b;
    endcase
  end
endmodule

// File: rtl/simd_mul_lane.sv
module simd_mul_lane #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);
  // Low word of the unsigned product
  assign y = a * b;
endmodule

// File: rtl/simd_cond_lane.sv
module simd_cond_lane
  import simd_pkg::*;
(
  input  wcond_e cond,
  input  logic   z,
  input  logic   n,
  output logic   pass
);
  always_comb begin
    case (cond)
      WC_NEVER:  pass = 1'b0;
      WC_ALWAYS: pass = 1'b1;
      WC_IFZ:    pass = z;
      WC_IFNZ:   pass = ~z;
      WC_IFN:    pass = n;
      WC_IFNN:   pass = ~n;
      default:   pass = 1'b0;
    endcase
  end
endmodule

// File: rtl/quad_simd_dp.sv
module quad_simd_dp
  import simd_pkg::*;
#(
  parameter int VEC_N = 16,
  parameter int LANES = 4,
  parameter int W     = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 issue,
  input  logic [2:0]           add_op,
  input  logic [2:0]           add_cond,
  input  logic [2:0]           mul_cond,
  input  logic                 set_flags,
  input  logic [VEC_N*W-1:0]   add_a,
  input  logic [VEC_N*W-1:0]   add_b,
  input  logic [VEC_N*W-1:0]   mul_a,
  input  logic [VEC_N*W-1:0]   mul_b,
  output logic                 busy,
  output logic                 done,
  output logic [VEC_N*W-1:0]   add_res,
  output logic [VEC_N*W-1:0]   mul_res,
  output logic [VEC_N-1:0]     add_wen,
  output logic [VEC_N-1:0]     mul_wen,
  output logic [VEC_N-1:0]     flag_z,
  output logic [VEC_N-1:0]     flag_n
);
  localparam int QUADS = VEC_N / LANES;
  localparam int PH_W  = (QUADS > 1) ? $clog2(QUADS) : 1;
  localparam int EI_W  = (VEC_N > 1) ? $clog2(VEC_N) : 1;
  localparam int VW    = VEC_N * W;
  localparam logic [PH_W-1:0] LAST = PH_W'(QUADS - 1);

  logic [PH_W-1:0] phase;
  logic [VW-1:0]   aa_q, ab_q, ma_q, mb_q;
  alu_op_e         op_q;
  wcond_e          ac_q, mc_q;
  logic            sf_q;

  logic            take, step, first;
  logic [VW-1:0]   aa_s, ab_s, ma_s, mb_s;
  alu_op_e         op_s;
  wcond_e          ac_s, mc_s;
  logic            sf_s;

  // Phase 0 reads the live ports; later phases read the captured copy
  assign first = (phase == '0);
  assign take  = issue && first;
  assign step  = take || !first;
  assign busy  = !first;

  assign aa_s = first ? add_a : aa_q;
  assign ab_s = first ? add_b : ab_q;
  assign ma_s = first ? mul_a : ma_q;
  assign mb_s = first ? mul_b : mb_q;
  assign op_s = first ? alu_op_e'(add_op)  : op_q;
  assign ac_s = first ? wcond_e'(add_cond) : ac_q;
  assign mc_s = first ? wcond_e'(mul_cond) : mc_q;
  assign sf_s = first ? set_flags : sf_q;

  logic [W-1:0]    lane_y [LANES];
  logic [W-1:0]    lane_p [LANES];
  logic [EI_W-1:0] lane_ei [LANES];
  logic [LANES-1:0] pass_a, pass_m;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_ei[l] = EI_W'(phase) * EI_W'(LANES) + EI_W'(l);

    simd_add_lane #(.W(W)) u_add (
      .op (op_s),
      .a  (aa_s[lane_ei[l]*W +: W]),
      .b  (ab_s[lane_ei[l]*W +: W]),
      .y  (lane_y[l])
    );

    simd_mul_lane #(.W(W)) u_mul (
      .a  (ma_s[lane_ei[l]*W +: W]),
      .b  (mb_s[lane_ei[l]*W +: W]),
      .y  (lane_p[l])
    );

    simd_cond_lane u_ca (
      .cond (ac_s),
      .z    (flag_z[lane_ei[l]]),
      .n    (flag_n[lane_ei[l]]),
      .pass (pass_a[l])
    );

    simd_cond_lane u_cm (
      .cond (mc_s),
      .z    (flag_z[lane_ei[l]]),
      .n    (flag_n[lane_ei[l]]),
      .pass (pass_m[l])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= '0;
      done    <= 1'b0;
      aa_q    <= '0;
      ab_q    <= '0;
      ma_q    <= '0;
      mb_q    <= '0;
      op_q    <= OP_ADD;
      ac_q    <= WC_NEVER;
      mc_q    <= WC_NEVER;
      sf_q    <= 1'b0;
      add_res <= '0;
      mul_res <= '0;
      add_wen <= '0;
      mul_wen <= '0;
      flag_z  <= '0;
      flag_n  <= '0;
    end else begin
      done <= step && (phase == LAST);
      if (take) begin
        aa_q <= add_a;
        ab_q <= add_b;
        ma_q <= mul_a;
        mb_q <= mul_b;
        op_q <= alu_op_e'(add_op);
        ac_q <= wcond_e'(add_cond);
        mc_q <= wcond_e'(mul_cond);
        sf_q <= set_flags;
      end
      if (step) begin
        phase <= (phase == LAST) ? '0 : phase + 1'b1;
        for (int l = 0; l < LANES; l++) begin
          add_res[lane_ei[l]*W +: W] <= lane_y[l];
          mul_res[lane_ei[l]*W +: W] <= lane_p[l];
          add_wen[lane_ei[l]]        <= pass_a[l];
          mul_wen[lane_ei[l]]        <= pass_m[l];
          if (sf_s) begin
            flag_z[lane_ei[l]] <= (lane_y[l] == '0);
            flag_n[lane_ei[l]] <= lane_y[l][W-1];
          end
        end
      end
    end
  end
endmodule

// File: rtl/quad_simd_chk.sv
module quad_simd_chk #(
  parameter int VEC_N = 16,
  parameter int LANES = 4,
  parameter int W     = 32
) (
  input logic                clk,
  input logic                rst,
  input logic                issue,
  input logic                busy,
  input logic                done,
  input logic [2:0]          add_op,
  input logic [2:0]          add_cond,
  input logic                set_flags,
  input logic [W-1:0]        a0,
  input logic [W-1:0]        b0,
  input logic [VEC_N*W-1:0]  add_res,
  input logic [LANES-1:0]    wen_q0,
  input logic [VEC_N-1:0]    flag_z,
  input logic [VEC_N-1:0]    flag_n
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!busy && !done && add_res == '0 && flag_z == '0 && flag_n == '0));

  // R5
  accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (issue && !busy) |=> busy);

  // R5
  done_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  // R5
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R8
  never_wen_chk: assert property (@(posedge clk) disable iff (rst)
    (issue && !busy && add_cond == 3'd0) |=> (wen_q0 == '0));

  // R7
  zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (issue && !busy && set_flags && add_op == 3'd3 && a0 == '0 && b0 == '0)
      |=> flag_z[0]);

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && !issue) |=> ($stable(flag_z) && $stable(flag_n) && $stable(add_res)));
endmodule

bind quad_simd_dp quad_simd_chk #(.VEC_N(VEC_N), .LANES(LANES), .W(W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .issue     (issue),
  .busy      (busy),
  .done      (done),
  .add_op    (add_op),
  .add_cond  (add_cond),
  .set_flags (set_flags),
  .a0        (add_a[W-1:0]),
  .b0        (add_b[W-1:0]),
  .add_res   (add_res),
  .wen_q0    (add_wen[LANES-1:0]),
  .flag_z    (flag_z),
  .flag_n    (flag_n)
);

// File: tb/sim_quad_simd_dp.sv
module sim_quad_simd_dp;
  localparam int N  = 16;
  localparam int VW = N * 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic issue = 1'b0;
  logic [2:0] add_op = '0, add_cond = '0, mul_cond = '0;
  logic set_flags = 1'b0;
  logic [VW-1:0] add_a = '0, add_b = '0, mul_a = '0, mul_b = '0;
  logic busy, done;
  logic [VW-1:0] add_res, mul_res;
  logic [N-1:0] add_wen, mul_wen, flag_z, flag_n;

  always #2 clk = ~clk;

  quad_simd_dp u0 (
    .clk(clk), .rst(rst), .issue(issue), .add_op(add_op), .add_cond(add_cond),
    .mul_cond(mul_cond), .set_flags(set_flags), .add_a(add_a), .add_b(add_b),
    .mul_a(mul_a), .mul_b(mul_b), .busy(busy), .done(done), .add_res(add_res),
    .mul_res(mul_res), .add_wen(add_wen), .mul_wen(mul_wen),
    .flag_z(flag_z), .flag_n(flag_n)
  );

  int checks = 0;
  int errs   = 0;
  bit finished = 1'b0;

  logic [VW-1:0] exp_add = '0, exp_mul = '0;
  logic [N-1:0]  exp_awe = '0, exp_mwe = '0, mz = '0, mn = '0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [VW-1:0] act, input logic [VW-1:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_alu(input int op, input logic [31:0] a, input logic [31:0] b);
    case (op)
      0: return a + b;
      1: return a - b;
      2: return a & b;
      3: return a | b;
      4: return a ^ b;
      5: return a << b[4:0];
      6: return a >> b[4:0];
      default: return $unsigned($signed(a) >>> b[4:0]);
    endcase
  endfunction

  function automatic bit ref_pass(input int c, input bit z, input bit n);
    case (c)
      1: return 1'b1;
      2: return z;
      3: return !z;
      4: return n;
      5: return !n;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [VW-1:0] rnd_vec();
    logic [VW-1:0] v;
    for (int e = 0; e < N; e++) v[e*32 +: 32] = $urandom;
    return v;
  endfunction

  // Called at a falling edge; returns at the falling edge where done is high
  task automatic run_instr(input int op, input int ca, input int cm, input bit sf,
                           input logic [VW-1:0] A, input logic [VW-1:0] B,
                           input logic [VW-1:0] C, input logic [VW-1:0] D,
                           input bit poke, input string req);
    logic [VW-1:0] prev;
    logic [N-1:0] nz, nn;
    prev = exp_add;
    nz = mz;
    nn = mn;
    for (int e = 0; e < N; e++) begin
      logic [31:0] r, p;
      r = ref_alu(op, A[e*32 +: 32], B[e*32 +: 32]);
      p = C[e*32 +: 32] * D[e*32 +: 32];
      exp_add[e*32 +: 32] = r;
      exp_mul[e*32 +: 32] = p;
      exp_awe[e] = ref_pass(ca, mz[e], mn[e]);
      exp_mwe[e] = ref_pass(cm, mz[e], mn[e]);
      if (sf) begin
        nz[e] = (r == 32'd0);
        nn[e] = r[31];
      end
    end
    mz = nz;
    mn = nn;

    add_op = 3'(op); add_cond = 3'(ca); mul_cond = 3'(cm); set_flags = sf;
    add_a = A; add_b = B; mul_a = C; mul_b = D;
    issue = 1'b1;
    @(negedge clk);
    issue = poke;
    if (poke) begin
      add_a = ~A; add_b = rnd_vec(); mul_a = rnd_vec(); mul_b = rnd_vec();
      add_op = 3'(op ^ 1); add_cond = 3'd0; mul_cond = 3'd0; set_flags = ~sf;
    end
    // R10: only elements 0-3 updated after the accepting edge
    chk(add_res[VW-1:128] == prev[VW-1:128], "R10", "upper elements kept",
        {128'd0, add_res[VW-1:128]}, {128'd0, prev[VW-1:128]});
    chk(add_res[127:0] == exp_add[127:0], "R10", "first quad written",
        {384'd0, add_res[127:0]}, {384'd0, exp_add[127:0]});
    for (int k = 0; k < 3; k++) begin
      if (k > 0) @(negedge clk);
      chk(busy === 1'b1 && done === 1'b0, "R5", "busy window",
          {510'd0, busy, done}, {510'd0, 2'b10});
    end
    @(negedge clk);
    issue = 1'b0;
    chk(busy === 1'b0 && done === 1'b1, "R5", "done pulse",
        {510'd0, busy, done}, {510'd0, 2'b01});
    chk(add_res === exp_add, req, "add_res", add_res, exp_add);
    chk(mul_res === exp_mul, req, "mul_res", mul_res, exp_mul);
    chk(add_wen === exp_awe, req, "add_wen (R8)", {496'd0, add_wen}, {496'd0, exp_awe});
    chk(mul_wen === exp_mwe, req, "mul_wen (R8)", {496'd0, mul_wen}, {496'd0, exp_mwe});
    chk(flag_z === mz, req, "flag_z (R7)", {496'd0, flag_z}, {496'd0, mz});
    chk(flag_n === mn, req, "flag_n (R7)", {496'd0, flag_n}, {496'd0, mn});
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errs);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errs++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [VW-1:0] A, B, C, D;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1
    chk(busy === 1'b0 && done === 1'b0, "R1", "control in reset",
        {510'd0, busy, done}, '0);
    chk(add_res === '0 && mul_res === '0, "R1", "results in reset",
        add_res | mul_res, '0);
    chk({add_wen, mul_wen, flag_z, flag_n} === '0, "R1", "masks and flags in reset",
        {448'd0, add_wen, mul_wen, flag_z, flag_n}, '0);
    rst = 1'b0;
    @(negedge clk);
    chk(busy === 1'b0 && add_res === '0, "R1", "idle after reset",
        {511'd0, busy}, '0);

    // R2 R3 R4: add with flag update, both units writing
    run_instr(0, 1, 1, 1'b1, rnd_vec(), rnd_vec(), rnd_vec(), rnd_vec(), 1'b0, "R2 R3 R4");

    // R2 R7: subtract giving zeros on even elements and negatives on odd
    A = rnd_vec(); B = A;
    for (int e = 1; e < N; e += 2) B[e*32 +: 32] = A[e*32 +: 32] + 32'd5;
    C = '1; D = '1;
    run_instr(1, 1, 1, 1'b1, A, B, C, D, 1'b0, "R2 R3 R7");

    // R7 R8: xor without flag update, masks from the previous flags
    run_instr(4, 2, 3, 1'b0, rnd_vec(), rnd_vec(), rnd_vec(), rnd_vec(), 1'b0, "R7 R8");
    run_instr(2, 4, 5, 1'b0, rnd_vec(), rnd_vec(), rnd_vec(), rnd_vec(), 1'b0, "R2 R8");

    // R2: shifts over the full amount range, multiply masked off
    B = '0;
    for (int e = 0; e < N; e++) B[e*32 +: 32] = 32'(e * 2 + 1);
    run_instr(5, 1, 0, 1'b1, rnd_vec(), B, rnd_vec(), rnd_vec(), 1'b0, "R2 R8");
    A = rnd_vec();
    for (int e = 0; e < N; e += 2) A[e*32 + 31] = 1'b1;
    run_instr(6, 3, 7, 1'b0, A, B, rnd_vec(), rnd_vec(), 1'b0, "R2 R8");
    run_instr(7, 4, 6, 1'b1, A, B, rnd_vec(), rnd_vec(), 1'b0, "R2 R8");

    // R9: move as OR with itself
    A = rnd_vec();
    A[0 +: 32] = 32'd0;
    run_instr(3, 1, 2, 1'b1, A, A, rnd_vec(), rnd_vec(), 1'b0, "R9");
    chk(add_res === A, "R9", "move copies source", add_res, A);

    // R6: issue and operands change while busy
    run_instr(0, 1, 1, 1'b0, rnd_vec(), rnd_vec(), rnd_vec(), rnd_vec(), 1'b1, "R6");
    @(negedge clk);
    chk(busy === 1'b0, "R6", "no extra instruction started", {511'd0, busy}, '0);
    chk(add_res === exp_add, "R6", "results held when idle (R7)", add_res, exp_add);

    // R7: all-zero OR sets every zero flag
    run_instr(3, 1, 1, 1'b1, '0, '0, rnd_vec(), '0, 1'b0, "R7 R3");
    run_instr(0, 2, 5, 1'b0, rnd_vec(), rnd_vec(), rnd_vec(), rnd_vec(), 1'b0, "R8 R4");

    @(negedge clk);
    summary();
  end
endmodule